// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host port and an external asynchronous static RAM with a 17-bit address and a 16-bit data path split into two byte lanes. The host offers one word-sized request at a time through a valid/ready handshake. Each request is either a read or a write and carries a two-bit lane mask. The controller turns each accepted request into the active-low chip-select, write-enable, output-enable and per-lane enable waveforms the RAM expects. For a read, it returns the word with a single-cycle completion pulse.

Every phase length is a clock-cycle count. Each count is derived at elaboration as the ceiling of a nanosecond minimum divided by the clock period. Those minimums are the read and write cycle time, the access time, the write pulse width, the data-to-strobe overlap and the time the RAM outputs take to float. The data pins are split into an output word, an output enable and an input word. The controller switches on its own drivers only after the RAM outputs are known to be released.

Writes are controlled by write enable. Chip select and the lane enables fall one cycle before write enable, and output enable stays high for the whole write, so the RAM never drives the pins during a write.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and directly after reset, req_ready is 1, ram_ce_n, ram_we_n, ram_oe_n and both ram_be_n bits are 1, ram_dq_oe is 0 and rsp_valid is 0.
- R2: Whenever req_ready is 1 (no request in flight), all strobes are high and ram_dq_oe is 0.
- R3: A read accepted at clock edge E drives ram_ce_n=0, ram_oe_n=0 and ram_we_n=1 for RD_CYC cycles starting the cycle after E. RD_CYC is the larger of the cycle-time and access-time counts. ram_be_n[i] is the inverse of req_be[i]; lane 0 carries data bits 7:0 and lane 1 carries bits 15:8.
- R4: A read samples ram_dq_i at the last edge of its strobe window. rsp_valid is 1 for exactly the next cycle, the same cycle in which the strobes rise. rsp_rdata holds the sampled word, with the lanes whose req_be bit is 0 forced to zero.
- R5: A write first holds ram_ce_n and the selected ram_be_n low, with ram_we_n=1, ram_oe_n=1 and ram_dq_oe=1, for one cycle. It then holds ram_we_n low for PULSE_CYC cycles, the larger of the pulse-width and data-overlap counts. Then all strobes are high for one cycle while ram_dq_oe stays 1, and after that ram_dq_oe is 0. ram_we_n and ram_oe_n are never low together.
- R6: ram_addr and ram_dq_o hold the accepted request's values for the whole access. Only lanes whose req_be bit is 1 get their ram_be_n bit driven low.
- R7: ram_dq_oe is never 1 while ram_oe_n is 0, nor within HZ_CYC cycles after ram_oe_n rises.
- R8: After acceptance, req_ready is 0 until the access ends. For a read, it returns to 1 HZ_CYC cycles after the strobes rise. For a write, it returns to 1 after 2+PULSE_CYC+WREC_CYC cycles, where WREC_CYC pads the write to the write-cycle count.
- R9: Each cycle count is ceil(ns/CLK_PERIOD_NS). With a 20 ns clock and minimums of 85/85/85/55/35/30 ns, this gives a 5-cycle read window, a 3-cycle write pulse and a 2-cycle float gap.
- R10: A request offered while req_ready is 0 is ignored. Its address, data and type never reach the RAM pins, and only the request present when req_ready is 1 is accepted.
- R11: A request with req_be=0 drives no ram_be_n bit low. Such a write leaves memory unchanged, and such a read returns rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 17 | RAM address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_be_n | output | 2 | RAM lane enables, active low |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enable for the controller's data drivers |
| ram_dq_i | input | 16 | Data pins as seen by the controller |

## Verification
A phase counter that is loaded or decremented wrongly shows as a strobe edge one or more cycles off. The per-cycle comparison catches this on the very cycle the edge was due, and the RAM model reports a short write pulse or a short read window when the strobe rises. A corrupted lane register or sequencer state appears on ram_be_n, ram_dq_oe or req_ready in the first cycle after acceptance. A capture fault appears only on the cycle of the completion pulse, as a wrong rsp_rdata lane. A driver switched on too early is reported as bus contention in the cycle it overlaps the RAM's float window.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STROBE,
    ST_RD_TAIL,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WR_TAIL
  } ctl_state_t;

  // ceiling of a nanosecond minimum over the clock period, at least one cycle
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        data[g*8 +: 8] <= '0;
      else if (capture)
        data[g*8 +: 8] <= lane_en[g] ? bus_in[g*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 85,
  parameter int T_AA_NS       = 85,
  parameter int T_WC_NS       = 85,
  parameter int T_WP_NS       = 55,
  parameter int T_DW_NS       = 35,
  parameter int T_HZ_NS       = 30
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_be,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic                    ram_ce_n,
  output logic                    ram_we_n,
  output logic                    ram_oe_n,
  output logic [DATA_W/8-1:0]     ram_be_n,
  output logic [DATA_W-1:0]       ram_dq_o,
  output logic                    ram_dq_oe,
  input  logic [DATA_W-1:0]       ram_dq_i
);

  localparam int LANES     = DATA_W / 8;
  localparam int RD_CYC    = imax(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_AA_NS, CLK_PERIOD_NS));
  localparam int PULSE_CYC = imax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_DW_NS, CLK_PERIOD_NS));
  localparam int HZ_CYC    = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
  localparam int WC_CYC    = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
  // setup cycle + pulse + hold cycle, padded up to the write cycle count
  localparam int WREC_CYC  = imax(WC_CYC - (PULSE_CYC + 2), 0);
  localparam int WTAIL_LEN = imax(WREC_CYC, 1);
  localparam int MAX_CYC   = imax(imax(RD_CYC, HZ_CYC), imax(PULSE_CYC, WTAIL_LEN));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  ctl_state_t       state_q, state_nxt;
  logic             accept;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_done;
  logic [LANES-1:0] lane_q, lane_nxt;
  logic             capture;
  logic             nxt_select, nxt_drive;

  assign accept = (state_q == ST_IDLE) && req_valid;

  // ---------------- sequencer ----------------
  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_valid) state_nxt = req_write ? ST_WR_SETUP : ST_RD_STROBE;
      ST_RD_STROBE: if (timer_done) state_nxt = ST_RD_TAIL;
      ST_RD_TAIL:   if (timer_done) state_nxt = ST_IDLE;
      ST_WR_SETUP:  if (timer_done) state_nxt = ST_WR_PULSE;
      ST_WR_PULSE:  if (timer_done) state_nxt = ST_WR_HOLD;
      ST_WR_HOLD:   if (timer_done) state_nxt = (WREC_CYC > 0) ? ST_WR_TAIL : ST_IDLE;
      ST_WR_TAIL:   if (timer_done) state_nxt = ST_IDLE;
      default:      state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end

  // each phase is timed by one shared counter, reloaded on every state change
  assign timer_load = (state_nxt != state_q);

  always_comb begin
    unique case (state_nxt)
      ST_RD_STROBE: timer_val = CNT_W'(RD_CYC - 1);
      ST_RD_TAIL:   timer_val = CNT_W'(HZ_CYC - 1);
      ST_WR_PULSE:  timer_val = CNT_W'(PULSE_CYC - 1);
      ST_WR_TAIL:   timer_val = CNT_W'(WTAIL_LEN - 1);
      default:      timer_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_done)
  );

  // ---------------- request capture ----------------
  assign lane_nxt = accept ? req_be : lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q   <= '0;
      ram_addr <= '0;
      ram_dq_o <= '0;
    end else if (accept) begin
      lane_q   <= req_be;
      ram_addr <= req_addr;
      ram_dq_o <= req_wdata;
    end
  end

  // ---------------- registered pin strobes ----------------
  assign nxt_select = (state_nxt == ST_RD_STROBE) || (state_nxt == ST_WR_SETUP) ||
                      (state_nxt == ST_WR_PULSE);
  assign nxt_drive  = (state_nxt == ST_WR_SETUP) || (state_nxt == ST_WR_PULSE) ||
                      (state_nxt == ST_WR_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_be_n  <= '1;
      ram_dq_oe <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      ram_ce_n  <= !nxt_select;
      ram_we_n  <= (state_nxt != ST_WR_PULSE);
      ram_oe_n  <= (state_nxt != ST_RD_STROBE);
      ram_be_n  <= nxt_select ? ~lane_nxt : '1;
      ram_dq_oe <= nxt_drive;
      req_ready <= (state_nxt == ST_IDLE);
    end
  end

  // ---------------- read return ----------------
  assign capture = (state_q == ST_RD_STROBE) && timer_done;

  sram_read_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .lane_en (lane_q),
    .bus_in  (ram_dq_i),
    .valid   (rsp_valid),
    .data    (rsp_rdata)
  );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W    = 17,
  parameter int LANES     = 2,
  parameter int HZ_CYC    = 3,
  parameter int PULSE_CYC = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic [LANES-1:0]  ram_be_n,
  input logic              ram_dq_oe,
  input logic [ADDR_W-1:0] ram_addr
);

  int oe_high_run;
  int we_low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_high_run <= HZ_CYC;
      we_low_run  <= 0;
    end else begin
      if (!ram_oe_n)              oe_high_run <= 0;
      else if (oe_high_run < HZ_CYC) oe_high_run <= oe_high_run + 1;
      if (!ram_we_n) begin
        if (we_low_run < PULSE_CYC) we_low_run <= we_low_run + 1;
      end else begin
        we_low_run <= 0;
      end
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_ce_n && ram_we_n && ram_oe_n && (&ram_be_n) && !ram_dq_oe));

  a_r3_read_we_high: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> (ram_we_n && !ram_ce_n && !ram_dq_oe));

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r5_we_inside_select: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_ce_n && ram_oe_n && ram_dq_oe));

  a_r5_select_before_we: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> ($past(!ram_ce_n) && $past(ram_dq_oe)));

  a_r9_we_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (we_low_run >= PULSE_CYC));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && $past(!ram_ce_n) && !req_ready) |-> $stable(ram_addr));

  a_r7_float_gap: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (ram_oe_n && oe_high_run >= HZ_CYC));

  a_r8_busy_on_done: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .HZ_CYC    (HZ_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ram_ce_n  (ram_ce_n),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_be_n  (ram_be_n),
  .ram_dq_oe (ram_dq_oe),
  .ram_addr  (ram_addr)
);

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;

  localparam int CP = 20;
  function automatic int cdiv(input int ns);
    return (ns + CP - 1) / CP;
  endfunction
  localparam int E_A  = (cdiv(85) > cdiv(85)) ? cdiv(85) : cdiv(85);
  localparam int E_P  = (cdiv(55) > cdiv(35)) ? cdiv(55) : cdiv(35);
  localparam int E_H  = cdiv(30);
  localparam int E_WR = (cdiv(85) - (E_P + 2) > 0) ? cdiv(85) - (E_P + 2) : 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [1:0]  ram_be_n;
  logic [15:0] ram_dq_o, ram_dq_i;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] last_rdata = '0;

  always #10 clk = ~clk;

  sram_strobe_ctrl #(.CLK_PERIOD_NS(CP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM ----------------
  logic [15:0] ram_mem [int];
  logic [15:0] shadow [int];

  always_comb begin
    logic [15:0] w;
    w = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 16'h0000;
    for (int l = 0; l < 2; l++)
      ram_dq_i[l*8 +: 8] = (!ram_ce_n && !ram_oe_n && ram_we_n && !ram_be_n[l]) ? w[l*8 +: 8] : 8'hA5;
  end

  // ---------------- expected cycle stream ----------------
  typedef struct {
    int          kind;   // 0 idle, 1 read, 2 write
    logic        ce, we, oe, doe, rdy, rv;
    logic [1:0]  be;
    logic [15:0] rd, wd;
    logic [16:0] addr;
  } exp_t;
  exp_t q[$];

  function automatic exp_t quiet(input logic rdy);
    exp_t e;
    e.kind = 0; e.ce = 1; e.we = 1; e.oe = 1; e.doe = 0; e.rdy = rdy; e.rv = 0;
    e.be = 2'b11; e.rd = '0; e.wd = '0; e.addr = '0;
    return e;
  endfunction

  function automatic logic [15:0] shadow_rd(input logic [16:0] a, input logic [1:0] be);
    logic [15:0] w, r;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    for (int l = 0; l < 2; l++) r[l*8 +: 8] = be[l] ? w[l*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic push_request(input logic wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    exp_t e;
    if (!wr) begin
      for (int k = 0; k < E_A; k++) begin
        e = quiet(0); e.kind = 1; e.ce = 0; e.oe = 0; e.be = ~be; e.addr = a; q.push_back(e);
      end
      e = quiet(0); e.rv = 1; e.rd = shadow_rd(a, be); q.push_back(e);
      for (int k = 1; k < E_H; k++) q.push_back(quiet(0));
    end else begin
      e = quiet(0); e.kind = 2; e.ce = 0; e.be = ~be; e.doe = 1; e.addr = a; e.wd = d; q.push_back(e);
      for (int k = 0; k < E_P; k++) begin
        e = quiet(0); e.kind = 2; e.ce = 0; e.we = 0; e.be = ~be; e.doe = 1; e.addr = a; e.wd = d;
        q.push_back(e);
      end
      e = quiet(0); e.kind = 2; e.doe = 1; e.wd = d; q.push_back(e);
      for (int k = 0; k < E_WR; k++) q.push_back(quiet(0));
      begin
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        for (int l = 0; l < 2; l++) if (be[l]) w[l*8 +: 8] = d[l*8 +: 8];
        shadow[int'(a)] = w;
      end
    end
  endtask

  // model state
  logic        p_we = 1, p_oe = 1, p_ce = 1;
  logic [1:0]  p_be = 2'b11;
  logic [16:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  int we_low = 0, oe_low = 0, float_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      string st;
      logic drive_now;
      e = (q.size() > 0) ? q.pop_front() : quiet(1);
      st = (e.kind == 1) ? "R3" : (e.kind == 2) ? "R5" : "R2";
      chk(st, "ce_n", ram_ce_n, e.ce);
      chk(st, "we_n", ram_we_n, e.we);
      chk(st, "oe_n", ram_oe_n, e.oe);
      chk((e.kind == 0) ? "R2" : "R6", "be_n", ram_be_n, e.be);
      chk("R7", "dq_oe", ram_dq_oe, e.doe);
      chk("R8", "req_ready", req_ready, e.rdy);
      chk("R4", "rsp_valid", rsp_valid, e.rv);
      if (e.rv) begin
        chk("R4", "rsp_rdata", rsp_rdata, e.rd);
        last_rdata = rsp_rdata;
      end
      if (!e.ce) chk("R6", "ram_addr", ram_addr, e.addr);
      if (e.doe) chk("R6", "ram_dq_o", ram_dq_o, e.wd);

      // RAM-side rules
      drive_now = !ram_ce_n && !ram_oe_n && ram_we_n && (ram_be_n != 2'b11);
      chk("R7", "bus contention", ram_dq_oe && (drive_now || float_cnt > 0), 0);
      chk("R5", "we/oe overlap", !ram_we_n && !ram_oe_n, 0);
      if (!p_we && ram_we_n) begin
        chk("R9", "write pulse cycles", we_low >= E_P, 1);
        if (!p_ce) begin
          logic [15:0] w;
          w = ram_mem.exists(int'(p_addr)) ? ram_mem[int'(p_addr)] : 16'h0000;
          for (int l = 0; l < 2; l++) if (!p_be[l]) w[l*8 +: 8] = p_dq[l*8 +: 8];
          ram_mem[int'(p_addr)] = w;
        end
      end
      if (!p_oe && ram_oe_n) chk("R9", "read window cycles", oe_low >= E_A, 1);
      we_low = ram_we_n ? 0 : we_low + 1;
      oe_low = ram_oe_n ? 0 : oe_low + 1;
      if (drive_now) float_cnt = E_H;
      else if (float_cnt > 0) float_cnt--;
      p_we = ram_we_n; p_oe = ram_oe_n; p_ce = ram_ce_n; p_be = ram_be_n;
      p_addr = ram_addr; p_dq = ram_dq_o;

      if (req_valid && req_ready) push_request(req_write, req_addr, req_wdata, req_be);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #5;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (E_A + E_H + E_P + 6) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (2) @(negedge clk);
    // R1: reset values
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "strobes", {ram_ce_n, ram_we_n, ram_oe_n, ram_be_n}, 5'b11111);
    chk("R1", "dq_oe/rsp_valid", {ram_dq_oe, rsp_valid}, 2'b00);
    @(posedge clk); #5; rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    @(posedge clk); #5;

    // full-word write and read back, incl. highest address
    issue(1, 17'h00010, 16'h1234, 2'b11);
    issue(0, 17'h00010, 16'h0000, 2'b11);
    issue(1, 17'h1FFFF, 16'hBEEF, 2'b11);
    issue(0, 17'h1FFFF, 16'h0000, 2'b11);
    // lane-masked writes and reads
    issue(1, 17'h00010, 16'hAAFF, 2'b01);
    issue(0, 17'h00010, 16'h0000, 2'b11);
    issue(1, 17'h00010, 16'h77CC, 2'b10);
    issue(0, 17'h00010, 16'h0000, 2'b10);
    issue(0, 17'h00010, 16'h0000, 2'b01);

    // R11: zero-mask write leaves memory, zero-mask read returns zero
    issue(1, 17'h00010, 16'h0F0F, 2'b00);
    issue(0, 17'h00010, 16'h0000, 2'b11);
    drain();
    chk("R11", "word after zero-mask write", last_rdata, 16'h77FF);
    issue(0, 17'h00010, 16'h0000, 2'b00);
    drain();
    chk("R11", "zero-mask read data", last_rdata, 16'h0000);

    // R10: request offered while busy is ignored
    issue(1, 17'h00100, 16'h1111, 2'b11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00200; req_wdata = 16'h2222; req_be = 2'b11;
    repeat (3) @(negedge clk);
    @(posedge clk); #5;
    issue(0, 17'h00100, 16'h0000, 2'b11);
    issue(0, 17'h00200, 16'h0000, 2'b11);
    drain();
    chk("R10", "busy-time request not written", last_rdata, 16'h0000);

    // mixed traffic, back to back
    for (int n = 0; n < 40; n++) begin
      logic [16:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[1:0])
        2'd0: a = 17'h00000;
        2'd1: a = 17'h00001;
        2'd2: a = 17'h1FFFF;
        default: a = 17'h0ABCD;
      endcase
      issue(lf[2], a, {lf[7:0], lf[15:8]} ^ 16'h5A3C, lf[4:3]);
    end
    drain();
    chk("R8", "expected stream drained", q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule